// File: doc/BRIEF.md
# Nibble Execute Datapath

This block carries out the data side of a small 4-bit controller. Each instruction cycle it receives one 8-bit opcode together with a valid strobe. It decodes the opcode and updates its registers in a single clock: the accumulator, a 3-bit page register, a 4-bit row register, a status flag, a compare flag and a 128-nibble scratch RAM. Program sequencing, branching and output latching sit outside the block. Those neighbours see the status flag, the status of the instruction before it, the compare flag, and the live accumulator and row values.

Immediate fields in the opcode are stored bit-reversed. Every 4-bit constant and every 3-bit constant is mirrored before use, and memory bit numbers count down from the top. Each arithmetic or compare instruction produces status by its own rule: carry out, no borrow, zero, or inequality. Instructions that define no status result report 1.

Top module: `nib_exec`

## Requirements
- R1: After reset the accumulator, page register and row register read 0, both status outputs read 1, the compare flag reads 0, and every RAM nibble holds 0.
- R2: While `op_valid` is low no register or RAM nibble changes, whatever the opcode and key inputs are.
- R3: The RAM word used by memory instructions is at address {page, row}, with the page in the upper 3 bits. 0x21 copies the word to A. 0x27 copies A to the word. 0x26 copies A to the word and then clears A. 0x03 exchanges A and the word. All four report status 1.
- R4: 0x06 adds the word to A, and 0x70-0x7E add (reversed low opcode nibble + 1) to A. Both keep the low 4 bits of the sum and set status to the carry out. 0x7F clears A with status 1.
- R5: Status-only compares: 0x00 gives word != A, 0x01 gives A <= word, 0x3F gives word != 0. 0x3C writes (word - A) mod 16 to A and gives status A <= word.
- R6: 0x07 loads (word - 1) mod 16 into A with status word >= 1. 0x3E loads (word + 1) mod 16 into A with status word == 15. 0x3D replaces A with (0 - A) mod 16 with status (old A == 0).
- R7: Row instructions: 0x40-0x4F load the reversed low nibble into the row register. 0x50-0x5F give status row != reversed low nibble. 0x04 decrements the row with status old row >= 1. 0x05 increments it with status old row == 15. 0x24 and 0x25 first store A to the word and then do the same as 0x04 and 0x05. 0x20 copies A to the row, 0x22 copies the word to the row, and 0x23 copies the row to A.
- R8: 0x60-0x6F write the reversed low nibble to the word and then increment the row modulo 16, with status 1.
- R9: 0x28-0x2F load the reversed low 3 opcode bits into the page register. 0x09 inverts page bit 2. Both report status 1.
- R10: 0x30-0x33 set, 0x34-0x37 clear and 0x38-0x3B test one bit of the word. The bit number is 3 minus the low two opcode bits. The test reports that bit as status, and the set and clear forms report status 1.
- R11: 0x02 sets both status and the compare flag to (row != A). No other opcode changes the compare flag.
- R12: 0x08 copies the 4-bit key input to A with status 1. 0x0E gives status (keys != 0).
- R13: Opcodes 0x0A-0x0D, 0x0F, 0x10-0x1F and 0x80-0xFF change no register and no RAM nibble, and report status 1.
- R14: Each executed instruction moves the previous status value to `last_status_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Executes `opcode` on this clock edge |
| opcode | input | 8 | Instruction byte |
| keys_i | input | 4 | Key lines read by the key instructions |
| status_o | output | 1 | Status produced by the latest instruction |
| last_status_o | output | 1 | Status produced by the instruction before it |
| sl_o | output | 1 | Row/accumulator compare flag |
| acc_o | output | 4 | Accumulator |
| y_o | output | 4 | Row register |

## Verification
The checker assumes that `opcode` and `keys_i` carry known values whenever `op_valid` is high. It also assumes that reset is asserted before the first instruction, so that every `$past` value it reads comes from an executed cycle. The stimulus drives all inputs on the falling edge and holds them for the whole cycle, so they are stable at every sampling edge. It enters each setup value (page, row, accumulator, RAM contents) only through executed opcodes, and it lowers `op_valid` only where it is testing that idle cycles hold all state. Every opcode from 0x00 to 0xFF is run against corner and pseudo-random register values. A memory read follows each one, so RAM and page effects reach the ports.

// File: rtl/nib_pkg.sv
package nib_pkg;

    localparam int NIB_W   = 4;
    localparam int PAGE_W  = 3;
    localparam int ROW_W   = 4;
    localparam int OPC_W   = 8;
    localparam int ADDR_W  = PAGE_W + ROW_W;
    localparam int BITSEL_W = $clog2(NIB_W);

    typedef enum logic [5:0] {
        K_NOP,
        K_MEM_NE_A,
        K_A_LE_MEM,
        K_Y_NE_A,
        K_SWAP,
        K_Y_DEC,
        K_Y_INC,
        K_ADD_MEM,
        K_MEM_DEC_A,
        K_KEYS_A,
        K_X_FLIP,
        K_KEYS_NZ,
        K_A_TO_Y,
        K_MEM_TO_A,
        K_MEM_TO_Y,
        K_Y_TO_A,
        K_ST_Y_DEC,
        K_ST_Y_INC,
        K_ST_CLR,
        K_ST,
        K_X_IMM,
        K_BIT_SET,
        K_BIT_CLR,
        K_BIT_TEST,
        K_SUB_FROM_MEM,
        K_NEG_A,
        K_MEM_INC_A,
        K_MEM_NZ,
        K_Y_IMM,
        K_Y_NE_IMM,
        K_MEM_IMM_YINC,
        K_ADD_IMM,
        K_A_CLR
    } op_kind_e;

    typedef struct packed {
        op_kind_e             kind;
        logic [NIB_W-1:0]     imm4;
        logic [PAGE_W-1:0]    imm3;
        logic [BITSEL_W-1:0]  bitsel;
    } dec_t;

    typedef struct packed {
        logic [NIB_W-1:0]  a;
        logic [PAGE_W-1:0] x;
        logic [ROW_W-1:0]  y;
        logic              st;
        logic              lst;
        logic              sl;
    } arch_t;

    function automatic logic [NIB_W-1:0] mirror4(input logic [NIB_W-1:0] v);
        logic [NIB_W-1:0] r;
        for (int i = 0; i < NIB_W; i++) r[i] = v[NIB_W-1-i];
        return r;
    endfunction

    function automatic logic [PAGE_W-1:0] mirror3(input logic [PAGE_W-1:0] v);
        logic [PAGE_W-1:0] r;
        for (int i = 0; i < PAGE_W; i++) r[i] = v[PAGE_W-1-i];
        return r;
    endfunction

endpackage

// File: rtl/nib_decode.sv
module nib_decode
    import nib_pkg::*;
(
    input  logic [OPC_W-1:0] opcode,
    output dec_t             dec
);
    op_kind_e kind_c;

    always_comb begin
        kind_c = K_NOP;
        casez (opcode)
            8'h00:        kind_c = K_MEM_NE_A;
            8'h01:        kind_c = K_A_LE_MEM;
            8'h02:        kind_c = K_Y_NE_A;
            8'h03:        kind_c = K_SWAP;
            8'h04:        kind_c = K_Y_DEC;
            8'h05:        kind_c = K_Y_INC;
            8'h06:        kind_c = K_ADD_MEM;
            8'h07:        kind_c = K_MEM_DEC_A;
            8'h08:        kind_c = K_KEYS_A;
            8'h09:        kind_c = K_X_FLIP;
            8'h0E:        kind_c = K_KEYS_NZ;
            8'h20:        kind_c = K_A_TO_Y;
            8'h21:        kind_c = K_MEM_TO_A;
            8'h22:        kind_c = K_MEM_TO_Y;
            8'h23:        kind_c = K_Y_TO_A;
            8'h24:        kind_c = K_ST_Y_DEC;
            8'h25:        kind_c = K_ST_Y_INC;
            8'h26:        kind_c = K_ST_CLR;
            8'h27:        kind_c = K_ST;
            8'b0010_1???: kind_c = K_X_IMM;
            8'b0011_00??: kind_c = K_BIT_SET;
            8'b0011_01??: kind_c = K_BIT_CLR;
            8'b0011_10??: kind_c = K_BIT_TEST;
            8'h3C:        kind_c = K_SUB_FROM_MEM;
            8'h3D:        kind_c = K_NEG_A;
            8'h3E:        kind_c = K_MEM_INC_A;
            8'h3F:        kind_c = K_MEM_NZ;
            8'b0100_????: kind_c = K_Y_IMM;
            8'b0101_????: kind_c = K_Y_NE_IMM;
            8'b0110_????: kind_c = K_MEM_IMM_YINC;
            8'h7F:        kind_c = K_A_CLR;
            8'b0111_????: kind_c = K_ADD_IMM;
            default:      kind_c = K_NOP;
        endcase
    end

    always_comb begin
        dec.kind   = kind_c;
        dec.imm4   = mirror4(opcode[NIB_W-1:0]);
        dec.imm3   = mirror3(opcode[PAGE_W-1:0]);
        dec.bitsel = BITSEL_W'(NIB_W - 1) - opcode[BITSEL_W-1:0];
    end

endmodule

// File: rtl/nib_alu.sv
module nib_alu
    import nib_pkg::*;
(
    input  dec_t              dec,
    input  arch_t             cur,
    input  logic [NIB_W-1:0]  mem_rd,
    input  logic [NIB_W-1:0]  keys,
    output arch_t             nxt,
    output logic              mem_we,
    output logic [NIB_W-1:0]  mem_wd
);
    logic [NIB_W:0]   sum_c;
    logic [NIB_W-1:0] mask_c;

    always_comb begin
        mask_c = NIB_W'(1) << dec.bitsel;
        sum_c  = '0;
        nxt    = cur;
        nxt.st = 1'b1;
        mem_we = 1'b0;
        mem_wd = cur.a;
        unique case (dec.kind)
            K_MEM_NE_A:  nxt.st = (mem_rd != cur.a);
            K_A_LE_MEM:  nxt.st = (cur.a <= mem_rd);
            K_MEM_NZ:    nxt.st = (mem_rd != '0);
            K_Y_NE_A: begin
                nxt.st = (cur.y != cur.a);
                nxt.sl = (cur.y != cur.a);
            end
            K_SWAP: begin
                mem_we = 1'b1;
                nxt.a  = mem_rd;
            end
            K_Y_DEC: begin
                nxt.st = (cur.y != '0);
                nxt.y  = cur.y - ROW_W'(1);
            end
            K_Y_INC: begin
                nxt.st = (cur.y == '1);
                nxt.y  = cur.y + ROW_W'(1);
            end
            K_ADD_MEM: begin
                sum_c  = {1'b0, cur.a} + {1'b0, mem_rd};
                nxt.a  = sum_c[NIB_W-1:0];
                nxt.st = sum_c[NIB_W];
            end
            K_ADD_IMM: begin
                sum_c  = {1'b0, cur.a} + {1'b0, dec.imm4} + (NIB_W+1)'(1);
                nxt.a  = sum_c[NIB_W-1:0];
                nxt.st = sum_c[NIB_W];
            end
            K_MEM_DEC_A: begin
                nxt.st = (mem_rd != '0);
                nxt.a  = mem_rd - NIB_W'(1);
            end
            K_MEM_INC_A: begin
                nxt.st = (mem_rd == '1);
                nxt.a  = mem_rd + NIB_W'(1);
            end
            K_SUB_FROM_MEM: begin
                nxt.st = (cur.a <= mem_rd);
                nxt.a  = mem_rd - cur.a;
            end
            K_NEG_A: begin
                nxt.st = (cur.a == '0);
                nxt.a  = ~cur.a + NIB_W'(1);
            end
            K_KEYS_A:    nxt.a  = keys;
            K_KEYS_NZ:   nxt.st = (keys != '0);
            K_X_FLIP:    nxt.x  = cur.x ^ PAGE_W'(1 << (PAGE_W - 1));
            K_X_IMM:     nxt.x  = dec.imm3;
            K_A_TO_Y:    nxt.y  = cur.a;
            K_MEM_TO_A:  nxt.a  = mem_rd;
            K_MEM_TO_Y:  nxt.y  = mem_rd;
            K_Y_TO_A:    nxt.a  = cur.y;
            K_ST:        mem_we = 1'b1;
            K_ST_CLR: begin
                mem_we = 1'b1;
                nxt.a  = '0;
            end
            K_ST_Y_DEC: begin
                mem_we = 1'b1;
                nxt.st = (cur.y != '0);
                nxt.y  = cur.y - ROW_W'(1);
            end
            K_ST_Y_INC: begin
                mem_we = 1'b1;
                nxt.st = (cur.y == '1);
                nxt.y  = cur.y + ROW_W'(1);
            end
            K_BIT_SET: begin
                mem_we = 1'b1;
                mem_wd = mem_rd | mask_c;
            end
            K_BIT_CLR: begin
                mem_we = 1'b1;
                mem_wd = mem_rd & ~mask_c;
            end
            K_BIT_TEST:  nxt.st = ((mem_rd & mask_c) != '0);
            K_Y_IMM:     nxt.y  = dec.imm4;
            K_Y_NE_IMM:  nxt.st = (cur.y != dec.imm4);
            K_MEM_IMM_YINC: begin
                mem_we = 1'b1;
                mem_wd = dec.imm4;
                nxt.y  = cur.y + ROW_W'(1);
            end
            K_A_CLR:     nxt.a  = '0;
            default: ;
        endcase
    end

endmodule

// File: rtl/nib_ram.sv
module nib_ram #(
    parameter int ADDR_W = 7,
    parameter int DATA_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wd,
    output logic [DATA_W-1:0] rd
);
    localparam int DEPTH = 1 << ADDR_W;

    logic [DATA_W-1:0] word_q [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                word_q[g] <= '0;
            else if (we && (addr == ADDR_W'(g)))
                word_q[g] <= wd;
        end
    end

    assign rd = word_q[addr];

endmodule

// File: rtl/nib_exec.sv
module nib_exec
    import nib_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             op_valid,
    input  logic [OPC_W-1:0] opcode,
    input  logic [NIB_W-1:0] keys_i,
    output logic             status_o,
    output logic             last_status_o,
    output logic             sl_o,
    output logic [NIB_W-1:0] acc_o,
    output logic [ROW_W-1:0] y_o
);
    arch_t             state_q;
    arch_t             state_d;
    arch_t             alu_nxt;
    dec_t              dec;
    logic              alu_we;
    logic [NIB_W-1:0]  alu_wd;
    logic [NIB_W-1:0]  mem_rd;
    logic [ADDR_W-1:0] mem_addr;

    assign mem_addr = {state_q.x, state_q.y};

    nib_decode u_dec (
        .opcode (opcode),
        .dec    (dec)
    );

    nib_alu u_alu (
        .dec    (dec),
        .cur    (state_q),
        .mem_rd (mem_rd),
        .keys   (keys_i),
        .nxt    (alu_nxt),
        .mem_we (alu_we),
        .mem_wd (alu_wd)
    );

    nib_ram #(
        .ADDR_W (ADDR_W),
        .DATA_W (NIB_W)
    ) u_ram (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (op_valid && alu_we),
        .addr  (mem_addr),
        .wd    (alu_wd),
        .rd    (mem_rd)
    );

    always_comb begin
        state_d = state_q;
        if (op_valid) begin
            state_d     = alu_nxt;
            state_d.lst = state_q.st;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.a   <= '0;
            state_q.x   <= '0;
            state_q.y   <= '0;
            state_q.st  <= 1'b1;
            state_q.lst <= 1'b1;
            state_q.sl  <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    assign status_o      = state_q.st;
    assign last_status_o = state_q.lst;
    assign sl_o          = state_q.sl;
    assign acc_o         = state_q.a;
    assign y_o           = state_q.y;

endmodule

// File: rtl/nib_exec_chk.sv
module nib_exec_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       op_valid,
    input logic [7:0] opcode,
    input logic       status_o,
    input logic       last_status_o,
    input logic       sl_o,
    input logic [3:0] acc_o,
    input logic [3:0] y_o
);
    assert_idle_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
        !op_valid |=> ($stable(acc_o) && $stable(y_o) && $stable(status_o) && $stable(sl_o)));

    assert_clear_acc_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 8'h7F) |=> (acc_o == 4'd0 && status_o));

    assert_negate_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 8'h3D) |=>
            (acc_o == 4'(4'd0 - $past(acc_o)) && status_o == ($past(acc_o) == 4'd0)));

    assert_row_imm_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:4] == 4'h4) |=>
            (y_o == {$past(opcode[0]), $past(opcode[1]), $past(opcode[2]), $past(opcode[3])}));

    assert_row_inc_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 8'h05) |=>
            (y_o == 4'($past(y_o) + 4'd1) && status_o == ($past(y_o) == 4'hF)));

    assert_store_rowinc_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode[7:4] == 4'h6) |=> (y_o == 4'($past(y_o) + 4'd1) && status_o));

    assert_cmp_flag_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode == 8'h02) |=> (sl_o == status_o));

    assert_sl_keep_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (op_valid && opcode != 8'h02) |=> $stable(sl_o));

    assert_last_shift_R14: assert property (@(posedge clk) disable iff (!rst_n)
        op_valid |=> (last_status_o == $past(status_o)));

endmodule

bind nib_exec nib_exec_chk u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .op_valid      (op_valid),
    .opcode        (opcode),
    .status_o      (status_o),
    .last_status_o (last_status_o),
    .sl_o          (sl_o),
    .acc_o         (acc_o),
    .y_o           (y_o)
);

// File: tb/tb_nib_exec.sv
module tb_nib_exec;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       op_valid = 1'b0;
    logic [7:0] opcode = 8'h00;
    logic [3:0] keys_i = 4'h0;
    logic       status_o, last_status_o, sl_o;
    logic [3:0] acc_o, y_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;

    logic [3:0] ma, my;
    logic [2:0] mx;
    logic       mst, mlst, msl;
    logic [3:0] mem [128];
    logic [31:0] lcg = 32'h1234_5678;

    always #2 clk = ~clk;

    nib_exec dut (
        .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .opcode(opcode), .keys_i(keys_i),
        .status_o(status_o), .last_status_o(last_status_o), .sl_o(sl_o),
        .acc_o(acc_o), .y_o(y_o)
    );

    function automatic logic [3:0] rv4(input logic [3:0] v);
        return {v[0], v[1], v[2], v[3]};
    endfunction

    function automatic logic [2:0] rv3(input logic [2:0] v);
        return {v[0], v[1], v[2]};
    endfunction

    function automatic string req_of(input logic [7:0] op);
        if (op == 8'h00 || op == 8'h01 || op == 8'h3C || op == 8'h3F) return "R5";
        if (op == 8'h02) return "R11";
        if (op == 8'h03 || op == 8'h21 || op == 8'h26 || op == 8'h27) return "R3";
        if (op == 8'h06 || op[7:4] == 4'h7) return "R4";
        if (op == 8'h07 || op == 8'h3D || op == 8'h3E) return "R6";
        if (op == 8'h08 || op == 8'h0E) return "R12";
        if (op == 8'h09 || op[7:3] == 5'b00101) return "R9";
        if (op[7:4] == 4'h3 && op[3:2] != 2'b11) return "R10";
        if (op[7:4] == 4'h6) return "R8";
        if (op == 8'h04 || op == 8'h05 || (op >= 8'h20 && op <= 8'h25) || op[7:5] == 3'b010) return "R7";
        return "R13";
    endfunction

    function automatic logic [31:0] next_rand();
        lcg = lcg * 32'd1664525 + 32'd1013904223;
        return lcg;
    endfunction

    task automatic check(input string tag, input string what, input logic [7:0] op,
                         input logic [3:0] act, input logic [3:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s op=%02h actual=%h expected=%h", tag, what, op, act, exp);
        end
    endtask

    task automatic model(input logic [7:0] op);
        logic [6:0] ad = {mx, my};
        logic [3:0] m  = mem[ad];
        logic [4:0] s;
        logic [1:0] b  = 2'd3 - op[1:0];
        logic       ns = 1'b1;
        casez (op)
            8'h00: ns = (m != ma);
            8'h01: ns = (ma <= m);
            8'h02: begin ns = (my != ma); msl = ns; end
            8'h03: begin mem[ad] = ma; ma = m; end
            8'h04: begin ns = (my >= 1); my = my - 1; end
            8'h05: begin ns = (my == 15); my = my + 1; end
            8'h06: begin s = ma + m; ma = s[3:0]; ns = s[4]; end
            8'h07: begin ns = (m >= 1); ma = m - 1; end
            8'h08: ma = keys_i;
            8'h09: mx = mx ^ 3'd4;
            8'h0E: ns = (keys_i != 0);
            8'h20: my = ma;
            8'h21: ma = m;
            8'h22: my = m;
            8'h23: ma = my;
            8'h24: begin mem[ad] = ma; ns = (my >= 1); my = my - 1; end
            8'h25: begin mem[ad] = ma; ns = (my == 15); my = my + 1; end
            8'h26: begin mem[ad] = ma; ma = 0; end
            8'h27: mem[ad] = ma;
            8'b0010_1???: mx = rv3(op[2:0]);
            8'b0011_00??: mem[ad] = m | (4'd1 << b);
            8'b0011_01??: mem[ad] = m & ~(4'd1 << b);
            8'b0011_10??: ns = m[b];
            8'h3C: begin ns = (ma <= m); ma = m - ma; end
            8'h3D: begin ns = (ma == 0); ma = 4'd0 - ma; end
            8'h3E: begin ns = (m == 15); ma = m + 1; end
            8'h3F: ns = (m != 0);
            8'b0100_????: my = rv4(op[3:0]);
            8'b0101_????: ns = (my != rv4(op[3:0]));
            8'b0110_????: begin mem[ad] = rv4(op[3:0]); my = my + 1; end
            8'h7F: ma = 0;
            8'b0111_????: begin s = ma + rv4(op[3:0]) + 1; ma = s[3:0]; ns = s[4]; end
            default: ;
        endcase
        mlst = mst;
        mst  = ns;
    endtask

    task automatic compare(input string tag, input logic [7:0] op);
        check(tag, "acc", op, acc_o, ma);
        check(tag, "row", op, y_o, my);
        check(tag, "status", op, {3'b0, status_o}, {3'b0, mst});
        check(tag, "sl", op, {3'b0, sl_o}, {3'b0, msl});
        check("R14", "last_status", op, {3'b0, last_status_o}, {3'b0, mlst});
    endtask

    task automatic exec(input logic [7:0] op);
        opcode   = op;
        op_valid = 1'b1;
        model(op);
        @(negedge clk);
        op_valid = 1'b0;
        compare(req_of(op), op);
    endtask

    initial begin
        #700000;
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog expired");
            $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
            $finish;
        end
    end

    initial begin
        ma = 0; mx = 0; my = 0; mst = 1; mlst = 1; msl = 0;
        for (int i = 0; i < 128; i++) mem[i] = 4'h0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports, RAM zero checked by reads
        compare("R1", 8'h00);
        for (int x = 0; x < 8; x += 3) begin
            exec(8'h28 | {5'b0, rv3(3'(x))});
            exec(8'h40 | {4'b0, rv4(4'(x * 5))});
            exec(8'h21);
            check("R1", "ram_reset", 8'h21, acc_o, 4'h0);
        end

        // R3/R8: fill RAM with known values, page by page
        for (int x = 0; x < 8; x++) begin
            exec(8'h28 | {5'b0, rv3(3'(x))});
            exec(8'h40);
            for (int i = 0; i < 16; i++)
                exec(8'h60 | {4'b0, rv4(4'(x * 5 + i * 3 + 1))});
        end

        // all opcodes, corner and pseudo-random setups
        for (int op = 0; op < 256; op++) begin
            for (int t = 0; t < 12; t++) begin
                logic [31:0] r = next_rand();
                logic [3:0] av = r[3:0];
                logic [3:0] yv = r[7:4];
                logic [2:0] xv = r[10:8];
                if (t == 0) begin av = 0;  yv = 0;  end
                if (t == 1) begin av = 15; yv = 15; end
                if (t == 2) begin av = 0;  yv = 15; end
                if (t == 3) begin av = 15; yv = 0;  end
                if (t == 4) begin av = yv; end
                exec(8'h28 | {5'b0, rv3(xv)});
                exec(8'h40 | {4'b0, rv4(av)});
                exec(8'h23);
                exec(8'h40 | {4'b0, rv4(yv)});
                if (t == 5) exec(8'h26);
                if (t == 6) begin exec(8'h7F); exec(8'h70 | {4'b0, rv4(4'd14)}); exec(8'h27); end
                keys_i = (t == 7) ? 4'h0 : r[15:12];
                exec(8'(op));
                exec(8'h21);
            end
        end

        // R2: idle cycles with an active-looking opcode leave everything unchanged
        exec(8'h28 | {5'b0, rv3(3'd5)});
        exec(8'h40 | {4'b0, rv4(4'd9)});
        exec(8'h3E);
        opcode = 8'h26; keys_i = 4'hF; op_valid = 1'b0;
        repeat (4) @(negedge clk);
        compare("R2", 8'h26);
        opcode = 8'h09;
        repeat (2) @(negedge clk);
        compare("R2", 8'h09);
        exec(8'h21);

        // R3: full readback of RAM
        for (int x = 0; x < 8; x++) begin
            exec(8'h28 | {5'b0, rv3(3'(x))});
            for (int y = 0; y < 16; y++) begin
                exec(8'h40 | {4'b0, rv4(4'(y))});
                exec(8'h21);
                check("R3", "readback", 8'h21, acc_o, mem[{3'(x), 4'(y)}]);
            end
        end

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule